// File: doc/BRIEF.md
# Ring-Linked Row Multiply-Accumulate Node

This block is one node in a chain of matrix-multiply engines, with one engine per output row. The nodes are joined in a ring by a one-way packet link. Each packet has three fields in a fixed order: a one-bit opcode, a target node identifier and a data word. A node takes the packets whose identifier matches its own and passes every other packet on to its neighbour, unchanged, after a single register stage.

Load packets addressed to the node fill its operand storage. The first `NB` words go into the row vector A. The next `NB*NB` words go into the tile B. An external sequencer waits for the node's ready output and then pulses start. The node then performs one multiply-accumulate per cycle into its result row C. A writeback packet addressed to the node makes it inject its C entries back onto the ring, tagged with its own identifier. Forwarded traffic keeps priority over this injection. C keeps accumulating across successive tiles until it is read out, and each entry clears as it leaves.

Top module: `pe_ring_node`

## Requirements
- R1: A valid input packet whose identifier differs from `NODE_ID` appears on the output one clock later with opcode, identifier and data unchanged, whatever its opcode.
- R2: A packet whose identifier equals `NODE_ID` is never forwarded.
- R3: Load packets (opcode 0) addressed to the node are written at an auto-incrementing pointer. Pointer 0..NB-1 holds A[k]. Pointer NB+k*NB+j holds B[k][j]. Loads after `NB+NB*NB` words, counted since the last accepted start, are ignored.
- R4: A start pulse seen while ready is high is accepted. It returns the load pointer to 0, and ready is low in the following cycle.
- R5: After an accepted start, ready returns high exactly NB*NB cycles later, with C[j] increased by the sum over k of A[k]*B[k][j], taken modulo 2^DATA_W.
- R6: C is not cleared by start, so successive computations accumulate into it.
- R7: A writeback packet (opcode 1) addressed to the node while ready is high makes the node emit NB packets with opcode 1, identifier `NODE_ID` and data C[0], C[1], …, C[NB-1] in that order. Each entry is zeroed as it is sent, and ready is low until the last one has left.
- R8: While the node is emitting, a packet to be forwarded takes the output in that cycle. The injection waits, and no C entry is lost or reordered.
- R9: Start and writeback requests that arrive while ready is low are ignored.
- R10: After reset, ready is high, the output is invalid, C is zero and the load pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_in_valid | input | 1 | Incoming packet present |
| pkt_in_op | input | 1 | Incoming opcode: 0 load, 1 writeback |
| pkt_in_id | input | ID_W | Incoming target node identifier |
| pkt_in_data | input | DATA_W | Incoming data word |
| start | input | 1 | Begin the tile computation |
| pkt_out_valid | output | 1 | Outgoing packet present |
| pkt_out_op | output | 1 | Outgoing opcode |
| pkt_out_id | output | ID_W | Outgoing identifier |
| pkt_out_data | output | DATA_W | Outgoing data word |
| ready | output | 1 | Node idle: computation finished and C stable |

## Verification
The hardest situation to reach is a forwarded packet colliding with the node's own result injection, because it needs a writeback request followed at once by foreign traffic in the exact cycles the node is draining. The stimulus issues the writeback request and then drives back-to-back packets for other nodes on the very next cycles. The scoreboard then expects both forwarded packets ahead of all C entries. Requests that must be ignored are sent mid-computation and mid-drain, and any packet they might cause would show up in the scoreboard as unexpected. The load pointer is driven past its end so that ignored words would corrupt the next result if they were taken.

// File: rtl/pe_ring_pkg.sv
package pe_ring_pkg;
    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_WBACK = 1'b1
    } pe_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MAC,
        ST_DRAIN
    } pe_state_e;
endpackage

// File: rtl/pe_operand_store.sv
module pe_operand_store #(
    parameter int NB     = 4,
    parameter int DATA_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [DATA_W-1:0]               wr_data,
    input  logic                            ptr_clr,
    input  logic [$clog2(NB+NB*NB)-1:0]     rd_a_idx,
    input  logic [$clog2(NB+NB*NB)-1:0]     rd_b_idx,
    output logic [DATA_W-1:0]               a_word,
    output logic [DATA_W-1:0]               b_word
);
    localparam int DEPTH = NB + NB * NB;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             ptr;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (st_q.ptr < PTR_W'(DEPTH))) begin
            st_d.mem[st_q.ptr[IDX_W-1:0]] = wr_data;
            st_d.ptr = st_q.ptr + 1'b1;
        end
        if (ptr_clr) begin
            st_d.ptr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a_word = st_q.mem[rd_a_idx];
    assign b_word = st_q.mem[rd_b_idx];
endmodule

// File: rtl/pe_c_bank.sv
module pe_c_bank #(
    parameter int NB     = 4,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_en,
    input  logic [$clog2(NB)-1:0]   acc_idx,
    input  logic [DATA_W-1:0]       acc_val,
    input  logic                    clr_en,
    input  logic [$clog2(NB)-1:0]   clr_idx,
    input  logic [$clog2(NB)-1:0]   rd_idx,
    output logic [DATA_W-1:0]       rd_word
);
    typedef struct packed {
        logic [NB-1:0][DATA_W-1:0] c;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (acc_en) begin
            bk_d.c[acc_idx] = bk_q.c[acc_idx] + acc_val;
        end
        if (clr_en) begin
            bk_d.c[clr_idx] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign rd_word = bk_q.c[rd_idx];
endmodule

// File: rtl/pe_ring_out.sv
module pe_ring_out #(
    parameter int ID_W   = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fwd_valid,
    input  logic              fwd_op,
    input  logic [ID_W-1:0]   fwd_id,
    input  logic [DATA_W-1:0] fwd_data,
    input  logic              inj_valid,
    input  logic [ID_W-1:0]   inj_id,
    input  logic [DATA_W-1:0] inj_data,
    output logic              inj_taken,
    output logic              out_valid,
    output logic              out_op,
    output logic [ID_W-1:0]   out_id,
    output logic [DATA_W-1:0] out_data
);
    import pe_ring_pkg::*;

    typedef struct packed {
        logic              vld;
        logic              op;
        logic [ID_W-1:0]   id;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t sl_d, sl_q;

    always_comb begin
        sl_d      = '0;
        inj_taken = 1'b0;
        if (fwd_valid) begin
            sl_d.vld  = 1'b1;
            sl_d.op   = fwd_op;
            sl_d.id   = fwd_id;
            sl_d.data = fwd_data;
        end else if (inj_valid) begin
            sl_d.vld  = 1'b1;
            sl_d.op   = OP_WBACK;
            sl_d.id   = inj_id;
            sl_d.data = inj_data;
            inj_taken = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sl_q <= '0;
        else        sl_q <= sl_d;
    end

    assign out_valid = sl_q.vld;
    assign out_op    = sl_q.op;
    assign out_id    = sl_q.id;
    assign out_data  = sl_q.data;
endmodule

// File: rtl/pe_ring_node.sv
module pe_ring_node #(
    parameter int NB      = 4,
    parameter int ID_W    = 4,
    parameter int DATA_W  = 32,
    parameter int NODE_ID = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_in_valid,
    input  logic              pkt_in_op,
    input  logic [ID_W-1:0]   pkt_in_id,
    input  logic [DATA_W-1:0] pkt_in_data,
    input  logic              start,
    output logic              pkt_out_valid,
    output logic              pkt_out_op,
    output logic [ID_W-1:0]   pkt_out_id,
    output logic [DATA_W-1:0] pkt_out_data,
    output logic              ready
);
    import pe_ring_pkg::*;

    localparam int J_W    = $clog2(NB);
    localparam int STEP_W = 2 * J_W;
    localparam int IDX_W  = $clog2(NB + NB * NB);
    localparam logic [ID_W-1:0] MY_ID = ID_W'(NODE_ID);

    typedef struct packed {
        pe_state_e         st;
        logic [STEP_W-1:0] step;
        logic [J_W-1:0]    drn;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              hit, fwd, load_en, ptr_clr;
    logic              mac_en, inj_valid, inj_taken;
    logic [J_W-1:0]    col_j, row_k;
    logic [IDX_W-1:0]  a_idx, b_idx;
    logic [DATA_W-1:0] a_word, b_word, c_word;

    assign hit     = pkt_in_valid && (pkt_in_id == MY_ID);
    assign fwd     = pkt_in_valid && !hit;
    assign load_en = hit && (pkt_in_op == OP_LOAD);
    assign col_j   = ctl_q.step[STEP_W-1:J_W];
    assign row_k   = ctl_q.step[J_W-1:0];
    assign a_idx   = IDX_W'(row_k);
    assign b_idx   = IDX_W'(NB) + IDX_W'({row_k, col_j});

    always_comb begin
        ctl_d     = ctl_q;
        ptr_clr   = 1'b0;
        mac_en    = 1'b0;
        inj_valid = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ptr_clr    = 1'b1;
                    ctl_d.st   = ST_MAC;
                    ctl_d.step = '0;
                end else if (hit && (pkt_in_op == OP_WBACK)) begin
                    ctl_d.st  = ST_DRAIN;
                    ctl_d.drn = '0;
                end
            end
            ST_MAC: begin
                mac_en     = 1'b1;
                ctl_d.step = ctl_q.step + 1'b1;
                if (ctl_q.step == STEP_W'(NB * NB - 1)) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            ST_DRAIN: begin
                inj_valid = 1'b1;
                if (inj_taken) begin
                    ctl_d.drn = ctl_q.drn + 1'b1;
                    if (ctl_q.drn == J_W'(NB - 1)) begin
                        ctl_d.st = ST_IDLE;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ready = (ctl_q.st == ST_IDLE);

    pe_operand_store #(.NB(NB), .DATA_W(DATA_W)) ops_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (load_en),
        .wr_data  (pkt_in_data),
        .ptr_clr  (ptr_clr),
        .rd_a_idx (a_idx),
        .rd_b_idx (b_idx),
        .a_word   (a_word),
        .b_word   (b_word)
    );

    pe_c_bank #(.NB(NB), .DATA_W(DATA_W)) cbank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_en  (mac_en),
        .acc_idx (col_j),
        .acc_val (a_word * b_word),
        .clr_en  (inj_taken),
        .clr_idx (ctl_q.drn),
        .rd_idx  (ctl_q.drn),
        .rd_word (c_word)
    );

    pe_ring_out #(.ID_W(ID_W), .DATA_W(DATA_W)) ring_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fwd_valid (fwd),
        .fwd_op    (pkt_in_op),
        .fwd_id    (pkt_in_id),
        .fwd_data  (pkt_in_data),
        .inj_valid (inj_valid),
        .inj_id    (MY_ID),
        .inj_data  (c_word),
        .inj_taken (inj_taken),
        .out_valid (pkt_out_valid),
        .out_op    (pkt_out_op),
        .out_id    (pkt_out_id),
        .out_data  (pkt_out_data)
    );
endmodule

// File: rtl/pe_ring_node_chk.sv
module pe_ring_node_chk #(
    parameter int ID_W    = 4,
    parameter int DATA_W  = 32,
    parameter int NODE_ID = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pkt_in_valid,
    input logic              pkt_in_op,
    input logic [ID_W-1:0]   pkt_in_id,
    input logic [DATA_W-1:0] pkt_in_data,
    input logic              start,
    input logic              pkt_out_valid,
    input logic              pkt_out_op,
    input logic [ID_W-1:0]   pkt_out_id,
    input logic [DATA_W-1:0] pkt_out_data,
    input logic              ready
);
    localparam logic [ID_W-1:0] MY_ID = ID_W'(NODE_ID);

    p_pass_one_hop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_in_valid && pkt_in_id != MY_ID) |=>
        (pkt_out_valid && pkt_out_op == $past(pkt_in_op) &&
         pkt_out_id == $past(pkt_in_id) && pkt_out_data == $past(pkt_in_data)));

    p_own_load_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_in_valid && pkt_in_id == MY_ID && !pkt_in_op) |=>
        !(pkt_out_valid && !pkt_out_op && pkt_out_id == MY_ID));

    p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready) |=> !ready);

    p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start && !(pkt_in_valid && pkt_in_id == MY_ID)) |=> ready);

    p_inject_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_out_valid && pkt_out_id == MY_ID) |-> pkt_out_op);
endmodule

bind pe_ring_node pe_ring_node_chk #(
    .ID_W(ID_W), .DATA_W(DATA_W), .NODE_ID(NODE_ID)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .pkt_in_valid  (pkt_in_valid),
    .pkt_in_op     (pkt_in_op),
    .pkt_in_id     (pkt_in_id),
    .pkt_in_data   (pkt_in_data),
    .start         (start),
    .pkt_out_valid (pkt_out_valid),
    .pkt_out_op    (pkt_out_op),
    .pkt_out_id    (pkt_out_id),
    .pkt_out_data  (pkt_out_data),
    .ready         (ready)
);

// File: tb/pe_ring_node_tb_top.sv
module pe_ring_node_tb_top;
    localparam int NB      = 4;
    localparam int NN      = NB * NB;
    localparam int ID_W    = 4;
    localparam int DATA_W  = 32;
    localparam int NODE_ID = 5;
    localparam int PW      = 1 + ID_W + DATA_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pkt_in_valid = 1'b0;
    logic              pkt_in_op = 1'b0;
    logic [ID_W-1:0]   pkt_in_id = '0;
    logic [DATA_W-1:0] pkt_in_data = '0;
    logic              start = 1'b0;
    logic              pkt_out_valid, pkt_out_op, ready;
    logic [ID_W-1:0]   pkt_out_id;
    logic [DATA_W-1:0] pkt_out_data;

    int checks = 0;
    int failures = 0;
    logic [PW-1:0]     exp_q[$];
    string             tag_q[$];
    logic [DATA_W-1:0] m_a [NB];
    logic [DATA_W-1:0] m_b [NN];
    logic [DATA_W-1:0] m_c [NB];

    always #5 clk = ~clk;

    pe_ring_node #(.NB(NB), .ID_W(ID_W), .DATA_W(DATA_W), .NODE_ID(NODE_ID)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .pkt_in_valid(pkt_in_valid), .pkt_in_op(pkt_in_op),
        .pkt_in_id(pkt_in_id), .pkt_in_data(pkt_in_data),
        .start(start),
        .pkt_out_valid(pkt_out_valid), .pkt_out_op(pkt_out_op),
        .pkt_out_id(pkt_out_id), .pkt_out_data(pkt_out_data),
        .ready(ready)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && pkt_out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2/R9 unexpected packet", {pkt_out_op, pkt_out_id, pkt_out_data}, 0);
            end else begin
                logic [PW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({pkt_out_op, pkt_out_id, pkt_out_data} == e, t,
                      {pkt_out_op, pkt_out_id, pkt_out_data}, e);
            end
        end
    end

    task automatic put(input logic op, input int id, input logic [DATA_W-1:0] data);
        pkt_in_valid = 1'b1;
        pkt_in_op    = op;
        pkt_in_id    = ID_W'(id);
        pkt_in_data  = data;
        if (id != NODE_ID) begin
            exp_q.push_back({op, ID_W'(id), data});
            tag_q.push_back("R1 forwarded packet");
        end
        @(negedge clk);
        pkt_in_valid = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic model_mac();
        for (int j = 0; j < NB; j++)
            for (int k = 0; k < NB; k++)
                m_c[j] = m_c[j] + m_a[k] * m_b[k*NB + j];
    endtask

    task automatic expect_drain(input string req);
        for (int j = 0; j < NB; j++) begin
            exp_q.push_back({1'b1, ID_W'(NODE_ID), m_c[j]});
            tag_q.push_back(req);
            m_c[j] = '0;
        end
    endtask

    task automatic wait_drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic load_all(input int seed, input int extra);
        for (int i = 0; i < NB + NN + extra; i++) begin
            logic [DATA_W-1:0] v;
            v = DATA_W'(seed * 7 + i * 3 + 1);
            if (i < NB) m_a[i] = v;
            else if (i < NB + NN) m_b[i - NB] = v;
            put(1'b0, NODE_ID, v);
        end
    endtask

    // start, check R4, count cycles to ready (R5); pre = cycles already spent
    task automatic run_tile(input int pre_ignored);
        int n;
        pulse_start();
        check(ready == 1'b0, "R4 ready low after start", ready, 0);
        n = 0;
        if (pre_ignored != 0) begin
            put(1'b1, NODE_ID, 32'h0);   // R9: writeback while busy ignored
            pulse_start();               // R9: start while busy ignored
            n = 2;
        end
        while (!ready && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(n == NN, "R5 compute cycles", n, NN);
        model_mac();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int j = 0; j < NB; j++) m_c[j] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(ready == 1'b1, "R10 ready after reset", ready, 1);
        check(pkt_out_valid == 1'b0, "R10 output idle after reset", pkt_out_valid, 0);

        // R1 forwarding, both opcodes, back to back
        put(1'b0, 3, 32'h1111_0000);
        put(1'b1, 9, 32'h2222_0000);
        put(1'b0, 15, 32'hdead_beef);
        wait_drain();

        // R10: writeback right after reset returns zeros
        put(1'b1, NODE_ID, 32'h0);
        expect_drain("R10 C zero after reset");
        wait_drain();

        // R3 load, R5 compute
        load_all(1, 0);
        @(negedge clk);
        check(pkt_out_valid == 1'b0, "R2 own load not forwarded", pkt_out_valid, 0);
        run_tile(0);

        // R7 drain with R8 collisions
        put(1'b1, NODE_ID, 32'h0);
        put(1'b0, 2, 32'haaaa_0001);
        put(1'b1, 12, 32'hbbbb_0002);
        expect_drain("R7/R8 drained C entry");
        wait_drain();
        check(ready == 1'b1, "R7 ready after drain", ready, 1);

        // R6 accumulate over two tiles, R9 ignored requests
        run_tile(1);
        run_tile(0);
        put(1'b1, NODE_ID, 32'h0);
        pulse_start();  // R9: start during drain ignored
        expect_drain("R6 accumulated C entry");
        wait_drain();
        check(ready == 1'b1, "R9 start in drain ignored", ready, 1);

        // R7 zeroing: second writeback returns zeros
        put(1'b1, NODE_ID, 32'h0);
        expect_drain("R7 entries cleared");
        wait_drain();

        // R3 overflow: start resets pointer (R4), extra loads ignored
        run_tile(0);
        load_all(4, 3);
        run_tile(0);
        put(1'b1, NODE_ID, 32'h0);
        expect_drain("R3 overflow loads ignored");
        wait_drain();

        check(exp_q.size() == 0, "R7 all packets seen", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule